// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of peripheral interrupt events (twelve by default) into one vectored request for a small 8-bit processor. Each source has a pending latch that an event pulse sets, and an enable bit that decides whether that latch may compete. A fixed-priority selector picks the lowest-numbered enabled pending source. The processor sees one interrupt request line, and it reads back a status byte that carries a pending-sense flag and the global enable flag.

When the processor acknowledges a request, the controller does three things in that same clock edge. It clears global enable, it clears the winning source's latch, and it registers the jump-table address of that source. The table has two-byte entries, and entry 0 is kept for reset, so source `k` maps to address `2*(k+1)`. Three strobes control global enable: one to disable, one to enable and one for return-from-interrupt. The pending-sense flag stays valid while global enable is off, so firmware can poll for interrupts.

Top module: `irq_vector_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending latch, every enable bit, global enable and `vec_addr`. After reset `irq` is 0 and `status` is 0x00, and enabling all sources afterwards still shows no pending interrupt.
- R2: A pulse on `src_evt[k]` sets latch `k` at the clock edge. If `k` is enabled, `status[7]` reads 1 right after that edge.
- R3: A pending latch whose enable bit is 0 does not set `status[7]` and cannot win. The latch keeps its state, so it shows up as soon as the enable is written to 1 through `en_we`/`en_wdata`.
- R4: When several enabled latches are pending, the lowest source index wins. Index 0 has the highest priority.
- R5: On an accepted acknowledge, `vec_addr` becomes `2*(k+1)` after that edge, where `k` is the winner. The value is always even, and address 0 (reset) is never produced. It holds until the next accepted acknowledge.
- R6: An accepted acknowledge clears global enable and the latch of the winner only. All other latches keep their state.
- R7: Global enable is controlled by the strobes. `di_stb` clears it. `ei_stb` or `reti_stb` sets it. A disable or an accepted acknowledge in the same cycle beats a set.
- R8: `irq` is 1 exactly when global enable is 1 and at least one enabled latch is pending.
- R9: `status[7]` reports enabled-pending and `status[2]` reports global enable. Every other status bit reads 0, and `status[7]` stays valid while global enable is 0.
- R10: If a source's event and the acknowledge that clears its latch arrive in the same cycle, the latch stays set.
- R11: `cpu_ack` while `irq` is 0 is ignored. Latches, global enable and `vec_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | NUM_SRC | Per-source event pulses; each sets its latch |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | NUM_SRC | New enable bits, one per source |
| cpu_ack | input | 1 | Interrupt acknowledge from the processor |
| di_stb | input | 1 | Disable-interrupts strobe |
| ei_stb | input | 1 | Enable-interrupts strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe; sets global enable |
| irq | output | 1 | Interrupt request to the processor |
| vec_addr | output | VEC_W | Registered jump-table address of the last serviced source |
| status | output | 8 | Status byte: bit 7 pending-sense, bit 2 global enable |

## Verification
The assertions assume that all strobes are synchronous to `clk`, and that `rst` is high at the first clock edge so that no property looks at state from before reset. They also assume the processor acknowledges only in a cycle where it samples `irq`. The design tolerates a stray acknowledge, but the strobe assertions treat an acknowledge without `irq` as a no-op. The stimulus drives every input one time unit after a rising edge and holds it for a full cycle. Each strobe is pulsed for exactly one cycle, and reset is applied for two edges at the start, so every input stays within these assumptions.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
   localparam int STAT_SENSE_BIT = 7;
   localparam int STAT_GIE_BIT   = 2;
   localparam int VEC_STRIDE_LOG = 1;   // two-byte table entries
   localparam int VEC_FIRST_SLOT = 1;   // slot 0 belongs to reset

   function automatic int slot_addr(input int idx);
      return (idx + VEC_FIRST_SLOT) << VEC_STRIDE_LOG;
   endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NUM_SRC = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   input  logic               en_we,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] en_o
);
   logic [NUM_SRC-1:0] en_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_latch
      logic pend_q;
      always_ff @(posedge clk) begin
         if (rst)
            pend_q <= 1'b0;
         else if (set_i[g])
            pend_q <= 1'b1;   // set beats clear
         else if (clr_i[g])
            pend_q <= 1'b0;
      end
      assign pend_o[g] = pend_q;
   end

   always_ff @(posedge clk) begin
      if (rst)
         en_q <= '0;
      else if (en_we)
         en_q <= en_wdata;
   end
   assign en_o = en_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 12,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic [NUM_SRC-1:0] onehot_o
);
   always_comb begin
      idx_o    = '0;
      onehot_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o    = IDX_W'(i);
            onehot_o = NUM_SRC'(1) << i;
         end
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
   input  logic clk,
   input  logic rst,
   input  logic ack_fire,
   input  logic di_stb,
   input  logic ei_stb,
   input  logic reti_stb,
   output logic gie_o
);
   logic gie_q;
   always_ff @(posedge clk) begin
      if (rst)
         gie_q <= 1'b0;
      else if (ack_fire || di_stb)
         gie_q <= 1'b0;
      else if (ei_stb || reti_stb)
         gie_q <= 1'b1;
   end
   assign gie_o = gie_q;
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
   import irq_vector_pkg::*;
#(
   parameter int NUM_SRC = 12,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               en_we,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic               cpu_ack,
   input  logic               di_stb,
   input  logic               ei_stb,
   input  logic               reti_stb,
   output logic               irq,
   output logic [VEC_W-1:0]   vec_addr,
   output logic [7:0]         status
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1) begin : g_bad_num
      $error("irq_vector_ctl: NUM_SRC must be at least 1");
   end
   if (VEC_W < 2 || VEC_W > 16 || slot_addr(NUM_SRC - 1) >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_vector_ctl: VEC_W cannot hold the highest table address");
   end

   logic [NUM_SRC-1:0] pend, en, masked, win_oh, clr;
   logic [IDX_W-1:0]   win_idx;
   logic               sense, gie, ack_fire;
   logic [VEC_W-1:0]   vec_q;

   assign masked   = pend & en;
   assign ack_fire = cpu_ack & irq;
   assign clr      = ack_fire ? win_oh : '0;

   irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk(clk), .rst(rst), .set_i(src_evt), .clr_i(clr),
      .en_we(en_we), .en_wdata(en_wdata), .pend_o(pend), .en_o(en)
   );

   irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
      .req_i(masked), .any_o(sense), .idx_o(win_idx), .onehot_o(win_oh)
   );

   irq_gie_ctl u_gie (
      .clk(clk), .rst(rst), .ack_fire(ack_fire), .di_stb(di_stb),
      .ei_stb(ei_stb), .reti_stb(reti_stb), .gie_o(gie)
   );

   always_ff @(posedge clk) begin
      if (rst)
         vec_q <= '0;
      else if (ack_fire)
         vec_q <= VEC_W'(slot_addr(int'(win_idx)));
   end

   assign irq      = gie & sense;
   assign vec_addr = vec_q;

   always_comb begin
      status                 = 8'h00;
      status[STAT_SENSE_BIT] = sense;
      status[STAT_GIE_BIT]   = gie;
   end
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk #(
   parameter int NUM_SRC = 12,
   parameter int VEC_W   = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               cpu_ack,
   input logic               di_stb,
   input logic               ei_stb,
   input logic               reti_stb,
   input logic               irq,
   input logic [VEC_W-1:0]   vec_addr,
   input logic [7:0]         status
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (status == 8'h00 && !irq && vec_addr == '0)); // R1

   AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
      irq == (status[2] && status[7])); // R8

   AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack && irq) |=> !status[2]); // R6

   AST_DI_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
      di_stb |=> !status[2]); // R7

   AST_EI_RAISES_GIE: assert property (@(posedge clk) disable iff (rst)
      ((ei_stb || reti_stb) && !di_stb && !(cpu_ack && irq)) |=> status[2]); // R7

   AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
      !(cpu_ack && irq) |=> $stable(vec_addr)); // R5

   AST_VEC_NOT_RESET: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack && irq) |=> (vec_addr != '0 && !vec_addr[0])); // R5

   AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (status & 8'h7B) == 8'h00); // R9

   AST_STRAY_ACK_GIE: assert property (@(posedge clk) disable iff (rst)
      (cpu_ack && !irq && !di_stb && !ei_stb && !reti_stb) |=> $stable(status[2])); // R11
endmodule

bind irq_vector_ctl irq_vector_ctl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .di_stb(di_stb), .ei_stb(ei_stb),
   .reti_stb(reti_stb), .irq(irq), .vec_addr(vec_addr), .status(status)
);

// File: tb/test_irq_vector_ctl.sv
module test_irq_vector_ctl;
   localparam int N = 12;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] src_evt = '0;
   logic         en_we = 1'b0;
   logic [N-1:0] en_wdata = '0;
   logic         cpu_ack = 1'b0, di_stb = 1'b0, ei_stb = 1'b0, reti_stb = 1'b0;
   logic         irq;
   logic [W-1:0] vec_addr;
   logic [7:0]   status;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_vector_ctl #(.NUM_SRC(N), .VEC_W(W)) i_irq_vector_ctl (
      .clk(clk), .rst(rst), .src_evt(src_evt), .en_we(en_we), .en_wdata(en_wdata),
      .cpu_ack(cpu_ack), .di_stb(di_stb), .ei_stb(ei_stb), .reti_stb(reti_stb),
      .irq(irq), .vec_addr(vec_addr), .status(status)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // apply currently driven inputs at one edge, then release strobes
   task automatic cyc();
      @(posedge clk);
      #1;
      src_evt = '0; en_we = 1'b0; cpu_ack = 1'b0;
      di_stb = 1'b0; ei_stb = 1'b0; reti_stb = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      cyc(); cyc();
      rst = 1'b0;
      chk("R1 irq", irq, 0);
      chk("R1 status", status, 8'h00);
      chk("R1 vec", vec_addr, 0);

      // R3: disabled source latches but stays hidden
      src_evt[3] = 1'b1; cyc();
      chk("R3 hidden", status[7], 0);
      en_we = 1'b1; en_wdata = '1; cyc();
      chk("R3 revealed", status[7], 1);
      chk("R9 gie clear", status[2], 0);
      chk("R8 no irq gie off", irq, 0);
      ei_stb = 1'b1; cyc();
      chk("R8 irq", irq, 1);
      cpu_ack = 1'b1; cyc();
      chk("R5 vec src3", vec_addr, 8);
      chk("R6 gie cleared", status[2], 0);
      chk("R6 latch cleared", status[7], 0);

      // R9/R11: sense while disabled, stray ack ignored
      src_evt[5] = 1'b1; cyc();
      chk("R9 sense gie off", status, 8'h80);
      chk("R9 irq low", irq, 0);
      cpu_ack = 1'b1; cyc();
      chk("R11 vec kept", vec_addr, 8);
      chk("R11 latch kept", status[7], 1);
      chk("R11 gie kept", status[2], 0);

      // R7 strobes
      di_stb = 1'b1; ei_stb = 1'b1; cyc();
      chk("R7 di beats ei", status[2], 0);
      ei_stb = 1'b1; cyc();
      chk("R7 ei sets", status[2], 1);
      chk("R9 both bits", status, 8'h84);
      di_stb = 1'b1; cyc();
      chk("R7 di clears", status[2], 0);
      reti_stb = 1'b1; cyc();
      chk("R7 reti sets", status[2], 1);
      cpu_ack = 1'b1; ei_stb = 1'b1; cyc();
      chk("R7 ack beats ei", status[2], 0);
      chk("R5 vec src5", vec_addr, 12);

      // R10: event and its own clear together
      src_evt[2] = 1'b1; reti_stb = 1'b1; cyc();
      cpu_ack = 1'b1; src_evt[2] = 1'b1; cyc();
      chk("R10 vec src2", vec_addr, 6);
      chk("R10 latch survives", status[7], 1);
      ei_stb = 1'b1; cyc();
      cpu_ack = 1'b1; cyc();
      chk("R10 second service", vec_addr, 6);
      chk("R10 drained", status[7], 0);

      // R2/R5 sweep over single sources
      for (int i = 0; i < N; i++) begin
         src_evt[i] = 1'b1; ei_stb = 1'b1; cyc();
         chk("R2 sense", status[7], 1);
         chk("R8 irq single", irq, 1);
         cpu_ack = 1'b1; cyc();
         chk("R5 vec single", vec_addr, 2 * (i + 1));
         chk("R6 single cleared", status[7], 0);
      end

      // R4/R6 sweep over all pairs
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            src_evt[i] = 1'b1; src_evt[j] = 1'b1; ei_stb = 1'b1; cyc();
            cpu_ack = 1'b1; cyc();
            chk("R4 winner", vec_addr, 2 * (i + 1));
            chk("R6 loser kept", status[7], 1);
            ei_stb = 1'b1; cyc();
            cpu_ack = 1'b1; cyc();
            chk("R4 runner-up", vec_addr, 2 * (j + 1));
            chk("R6 pair drained", status[7], 0);
         end
      end

      // R1: reset with pending state, then re-enable
      src_evt = '1; ei_stb = 1'b1; cyc();
      rst = 1'b1; cyc(); rst = 1'b0;
      chk("R1 reset status", status, 8'h00);
      chk("R1 reset vec", vec_addr, 0);
      en_we = 1'b1; en_wdata = '1; cyc();
      chk("R1 latches clear", status[7], 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule